// File: doc/BRIEF.md
# Dual-Enable Byte Memory Bus Front End

This block sits between a byte-wide memory bus with loose, asynchronous-style control pins and an on-chip 8192 x 8 storage array. The bus carries a 13-bit address, a byte of write data, an active-low write enable, two chip selects of opposite polarity (one active-low, one active-high) and an active-low output enable. All pins are registered once on the system clock. The block then decodes read, write and deselect states from the registered pins.

A write window exists only while the write enable and both chip selects are asserted together. The window opens on whichever of the three arrives last and closes on whichever drops first. On the clock after the window closes, the byte last seen inside the window is committed to the array. The commit (strobe, address, byte) and the read path (registered read address and read byte) are exported, so that a register overlay placed over part of the address space can share the same bus. The read-data drive enable follows the two chip selects and the output enable. An asserted write enable blocks it.

Top module: `bytebus_sram_front`

## Requirements
- R1: With write enable high, the active-low select low, the active-high select high and output enable low, `rdata_oe_o` is 1 two clock edges after the pins are applied, and `rdata_o` holds the stored byte at `addr_i`.
- R2: `rdata_oe_o` is 0 whenever, two edges earlier, the active-low select was high, the active-high select was low, output enable was high, or write enable was low (the last case applies even with output enable low).
- R3: If only two of the three write conditions (write enable low, active-low select low, active-high select high) hold, no commit occurs: `wr_strobe_o` stays 0 and the addressed byte keeps its value.
- R4: A write window opens only when the last of the three write conditions becomes true, in any order of arrival. The address must not change while the window is open.
- R5: A window closes on the first of the three conditions to become false, whichever it is. Exactly one single-cycle `wr_strobe_o` pulse follows, two edges after the closing pin change. `wr_addr_o` carries the window address and the array is updated by that same edge.
- R6: When write data changes inside a window, the committed byte (`wr_data_o` and array content) is the value present at the last edge where the window was still open. A value applied together with the closing change is discarded.
- R7: Changing `addr_i` during a continuous read updates `rdata_o` two edges after the change, with no deselect; one edge after the change `rdata_o` still shows the previous address's byte.
- R8: While `rst` is high, `rdata_oe_o`, `wr_strobe_o` and `rdata_o` are 0.
- R9: All 13 address bits are decoded: addresses 0x0000 and 0x1FFF, and other distinct addresses, hold independent bytes.
- R10: Two windows separated by a single closed cycle each produce their own commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 13 | Bus byte address |
| wdata_i | input | 8 | Bus write data |
| we_n_i | input | 1 | Write enable, active low |
| sel_n_i | input | 1 | Chip select, active low |
| sel_i | input | 1 | Chip select, active high |
| oe_n_i | input | 1 | Output enable, active low |
| rdata_o | output | 8 | Registered read byte |
| rdata_oe_o | output | 1 | Drive enable for the bus data pins |
| rd_addr_o | output | 13 | Registered address used by the read path |
| wr_strobe_o | output | 1 | One-cycle commit pulse |
| wr_addr_o | output | 13 | Address of the committed byte |
| wr_data_o | output | 8 | Committed byte |

## Verification
Read results (`rdata_o`, `rdata_oe_o`) are due two edges after a pin change: one edge for the pin register and one for the synchronous array read. A commit is due two edges after the closing change, one to sample the closure and one to write. The bench drives pins on the falling edge, then waits the exact number of falling edges before sampling. For R7 it also samples one edge early to confirm the old byte is still present. For the no-commit cases it samples `wr_strobe_o` on every cycle of the hold and of the idle period that follows.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef struct packed {
    logic we_n;
    logic sel_n;
    logic sel;
    logic oe_n;
  } bus_ctl_t;

  localparam bus_ctl_t CTL_IDLE = '{we_n: 1'b1, sel_n: 1'b1, sel: 1'b0, oe_n: 1'b1};

  function automatic logic chip_on(input bus_ctl_t c);
    return !c.sel_n && c.sel;
  endfunction
endpackage

// File: rtl/bbs_pin_sync.sv
module bbs_pin_sync
  import bbs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  bus_ctl_t          ctl_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output bus_ctl_t          ctl_q,
  output logic              wr_open,
  output logic              rd_drive
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
      ctl_q  <= CTL_IDLE;
    end else begin
      addr_q <= addr_i;
      data_q <= data_i;
      ctl_q  <= ctl_i;
    end
  end

  always_comb begin
    wr_open  = chip_on(ctl_q) && !ctl_q.we_n;
    rd_drive = chip_on(ctl_q) && ctl_q.we_n && !ctl_q.oe_n;
  end
endmodule

// File: rtl/bbs_write_frame.sv
module bbs_write_frame #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [DATA_W-1:0] cm_data_o,
  output logic              strobe_q,
  output logic [ADDR_W-1:0] st_addr_q,
  output logic [DATA_W-1:0] st_data_q
);
  logic              win_q;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      win_q <= open_i;
      if (open_i) begin
        cap_addr <= addr_i;
        cap_data <= data_i;
      end
    end
  end

  assign commit_o  = win_q && !open_i;
  assign cm_addr_o = cap_addr;
  assign cm_data_o = cap_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q  <= 1'b0;
      st_addr_q <= '0;
      st_data_q <= '0;
    end else begin
      strobe_q <= commit_o;
      if (commit_o) begin
        st_addr_q <= cap_addr;
        st_data_q <= cap_data;
      end
    end
  end

  // Bus protocol: address held for the whole window.
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (open_i && win_q) |-> (addr_i == cap_addr));

  // A commit never follows a commit directly: a window lasts at least one edge.
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    strobe_q |=> !strobe_q);
endmodule

// File: rtl/bbs_store.sv
module bbs_store #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= mem[raddr_i];
  end
endmodule

// File: rtl/bytebus_sram_front.sv
module bytebus_sram_front
  import bbs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_n_i,
  input  logic              sel_n_i,
  input  logic              sel_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_strobe_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  bus_ctl_t          ctl_in, ctl_s;
  logic [ADDR_W-1:0] addr_s, cm_addr;
  logic [DATA_W-1:0] data_s, cm_data;
  logic              wr_open, rd_drive, commit;
  logic              oe_q;

  assign ctl_in = '{we_n: we_n_i, sel_n: sel_n_i, sel: sel_i, oe_n: oe_n_i};

  bbs_pin_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst(rst), .addr_i(addr_i), .data_i(wdata_i), .ctl_i(ctl_in),
    .addr_q(addr_s), .data_q(data_s), .ctl_q(ctl_s),
    .wr_open(wr_open), .rd_drive(rd_drive)
  );

  bbs_write_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .open_i(wr_open), .addr_i(addr_s), .data_i(data_s),
    .commit_o(commit), .cm_addr_o(cm_addr), .cm_data_o(cm_data),
    .strobe_q(wr_strobe_o), .st_addr_q(wr_addr_o), .st_data_q(wr_data_o)
  );

  bbs_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .we_i(commit), .waddr_i(cm_addr), .wdata_i(cm_data),
    .raddr_i(addr_s), .rdata_q(rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q      <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      oe_q      <= rd_drive;
      rd_addr_o <= addr_s;
    end
  end
  assign rdata_oe_o = oe_q;

  // Drive enable only after a cycle with write enable released.
  assert_oe_blocked_by_we_R2: assert property (@(posedge clk) disable iff (rst)
    rdata_oe_o |-> $past(ctl_s.we_n));

  // Drive enable needs both selects and output enable one cycle earlier.
  assert_oe_needs_selects_R1: assert property (@(posedge clk) disable iff (rst)
    rdata_oe_o |-> ($past(!ctl_s.sel_n) && $past(ctl_s.sel) && $past(!ctl_s.oe_n)));

  // A commit pulse needs all three write conditions two cycles back and a break one cycle back.
  assert_commit_needs_full_window_R3: assert property (@(posedge clk) disable iff (rst)
    wr_strobe_o |-> ($past(wr_open, 2) && !$past(wr_open, 1)));

  // Committed byte is the one present at the last open edge.
  assert_commit_data_R6: assert property (@(posedge clk) disable iff (rst)
    wr_strobe_o |-> (wr_data_o == $past(data_s, 2)));
endmodule

// File: tb/bytebus_sram_front_test.sv
module bytebus_sram_front_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        we_n = 1'b1, sel_n = 1'b1, sel = 1'b0, oe_n = 1'b1;
  logic [7:0]  rdata_o, wr_data_o;
  logic        rdata_oe_o, wr_strobe_o;
  logic [12:0] rd_addr_o, wr_addr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bytebus_sram_front uut (
    .clk(clk), .rst(rst), .addr_i(addr), .wdata_i(wdata), .we_n_i(we_n),
    .sel_n_i(sel_n), .sel_i(sel), .oe_n_i(oe_n), .rdata_o(rdata_o),
    .rdata_oe_o(rdata_oe_o), .rd_addr_o(rd_addr_o), .wr_strobe_o(wr_strobe_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  // {address, byte}
  localparam logic [20:0] VEC [8] = '{
    {13'h0000, 8'h5A}, {13'h1FFF, 8'hA5}, {13'h0001, 8'h3C}, {13'h1000, 8'hC3},
    {13'h0FFF, 8'h01}, {13'h0800, 8'hFE}, {13'h1555, 8'h77}, {13'h0AAA, 8'h88}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    we_n = 1'b1; sel_n = 1'b1; sel = 1'b0; oe_n = 1'b1;
  endtask

  task automatic set_sig(input int i, input bit on);
    case (i)
      0: we_n  = !on;
      1: sel_n = !on;
      default: sel = on;
    endcase
  endtask

  // One-edge window closed by write enable; checks the commit port (R5).
  task automatic write_byte(input logic [12:0] a, input logic [7:0] d);
    addr = a; wdata = d; we_n = 1'b0; sel_n = 1'b0; sel = 1'b1; oe_n = 1'b1;
    step(1);
    we_n = 1'b1;
    step(1);
    check("R5 no strobe before commit edge", wr_strobe_o, 1'b0);
    step(1);
    check("R5 strobe", wr_strobe_o, 1'b1);
    check("R5 wr_addr", wr_addr_o, a);
    check("R5 wr_data", wr_data_o, d);
    idle();
    step(1);
    check("R5 single pulse", wr_strobe_o, 1'b0);
  endtask

  task automatic read_check(input string req, input logic [12:0] a, input logic [7:0] exp);
    addr = a; we_n = 1'b1; sel_n = 1'b0; sel = 1'b1; oe_n = 1'b0;
    step(2);
    check({req, " oe"}, rdata_oe_o, 1'b1);
    check({req, " data"}, rdata_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    // R8 reset state
    check("R8 rdata_oe", rdata_oe_o, 1'b0);
    check("R8 strobe", wr_strobe_o, 1'b0);
    check("R8 rdata", rdata_o, 8'h00);
    rst = 1'b0;
    step(2);

    // Vector table: write all, then read all (R1, R9)
    for (int i = 0; i < 8; i++) write_byte(VEC[i][20:8], VEC[i][7:0]);
    for (int i = 0; i < 8; i++) read_check("R1 R9 readback", VEC[i][20:8], VEC[i][7:0]);

    // R2: each blocking condition while otherwise reading addr 0
    for (int k = 0; k < 4; k++) begin
      addr = 13'h0000; wdata = 8'h5A; we_n = 1'b1; sel_n = 1'b0; sel = 1'b1; oe_n = 1'b0;
      case (k)
        0: sel_n = 1'b1;
        1: sel = 1'b0;
        2: oe_n = 1'b1;
        default: we_n = 1'b0; // rewrites the same byte
      endcase
      step(2);
      check("R2 oe blocked", rdata_oe_o, 1'b0);
      idle();
      step(3);
    end
    read_check("R2 content kept", 13'h0000, 8'h5A);

    // R3: two of three conditions never commit
    for (int m = 0; m < 3; m++) begin
      addr = 13'h1555; wdata = 8'hEE; oe_n = 1'b1;
      we_n = 1'b0; sel_n = 1'b0; sel = 1'b1;
      set_sig(m, 1'b0);
      for (int c = 0; c < 4; c++) begin
        step(1);
        check("R3 no strobe partial", wr_strobe_o, 1'b0);
      end
      idle();
      for (int c = 0; c < 3; c++) begin
        step(1);
        check("R3 no strobe after partial", wr_strobe_o, 1'b0);
      end
      read_check("R3 byte unchanged", 13'h1555, 8'h77);
    end

    // R4 R5 R6: arrival orders, closing by each signal, data changes in window
    for (int k = 0; k < 3; k++) begin
      idle();
      addr = 13'h0123 + 13'(k);
      wdata = 8'h10;
      set_sig((k + 1) % 3, 1'b1); step(1);
      set_sig((k + 2) % 3, 1'b1); step(1);
      check("R4 no strobe before last edge", wr_strobe_o, 1'b0);
      wdata = 8'hA0 + 8'(k);
      set_sig(k, 1'b1); step(1);
      wdata = 8'hB0 + 8'(k); step(1);
      wdata = 8'hCC;
      set_sig(k, 1'b0); step(1);
      check("R5 no early strobe", wr_strobe_o, 1'b0);
      step(1);
      check("R5 strobe on close", wr_strobe_o, 1'b1);
      check("R5 close addr", wr_addr_o, 13'h0123 + 13'(k));
      check("R6 last open data", wr_data_o, 8'hB0 + 8'(k));
      idle(); step(1);
      check("R5 one pulse", wr_strobe_o, 1'b0);
      read_check("R6 array data", 13'h0123 + 13'(k), 8'hB0 + 8'(k));
    end

    // R7: address change during read
    read_check("R7 first", 13'h0001, 8'h3C);
    addr = 13'h1000;
    step(1);
    check("R7 old byte one edge later", rdata_o, 8'h3C);
    step(1);
    check("R7 new byte two edges later", rdata_o, 8'hC3);
    check("R7 oe held", rdata_oe_o, 1'b1);

    // R10: back-to-back windows with one closed cycle
    idle(); step(1);
    addr = 13'h0200; wdata = 8'h21; we_n = 1'b0; sel_n = 1'b0; sel = 1'b1;
    step(1);
    we_n = 1'b1; step(1);
    addr = 13'h0201; wdata = 8'h43; we_n = 1'b0; step(1);
    check("R10 first strobe", wr_strobe_o, 1'b1);
    check("R10 first addr", wr_addr_o, 13'h0200);
    we_n = 1'b1; step(1);
    check("R10 gap", wr_strobe_o, 1'b0);
    step(1);
    check("R10 second strobe", wr_strobe_o, 1'b1);
    check("R10 second data", wr_data_o, 8'h43);
    idle(); step(1);
    read_check("R10 first byte", 13'h0200, 8'h21);
    read_check("R10 second byte", 13'h0201, 8'h43);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule